// File: doc/BRIEF.md
# 8-bit ALU with Per-Operation Flag Update

This block is the combinational arithmetic and logic unit of a small 8-bit microcontroller core. It takes two operands, the current carry and the current zero flag from the status register, and a 4-bit operation code. It returns a result byte, a write-back enable for the destination register, a new flag vector, and a mask. The mask marks the flags that the operation owns. The core merges the new flags into its status register under that mask, so every flag outside the mask keeps its old value.

All additive operations share one adder/subtractor. Immediate forms use the same codes: the decoder places the constant on `b_i`. Compare forms compute the subtraction but do not write back. Increment and decrement leave carry and half-carry alone. The with-carry subtract and compare forms can only clear Z. This lets a multi-byte compare end with Z set only when every byte matched.

Top module: `alu8_core`

## Requirements
- R1: ADD (op 0) returns a+b and ADC (op 1) returns a+b+carry_i. Both have mask 5'b11111. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, N is result bit 7, and Z means the result is zero. Flag bits are: C bit 0, Z bit 1, N bit 2, V bit 3, H bit 4.
- R2: SUB (op 2) returns a−b and SBC (op 3) returns a−b−carry_i, with mask 5'b11111. C is the borrow out of bit 7, H is the borrow into bit 4, and V is signed overflow.
- R3: CP (op 13) and CPC (op 14) compute the same flags and mask as SUB and SBC, and hold wr_en_o at 0.
- R4: For SBC and CPC, Z equals zero_i AND (result == 0). A zero result never sets Z on its own.
- R5: AND (op 4), OR (op 5), XOR (op 6) and clear-bits ANDN (op 7, a AND NOT b) use mask 5'b01110 with V = 0. Set-bits uses OR.
- R6: COM (op 8) returns NOT a, with mask 5'b01111, C = 1 and V = 0.
- R7: NEG (op 9) returns 0−a, with mask 5'b11111. C is 1 exactly when a is nonzero. V is 1 only for a = 0x80.
- R8: INC (op 10) and DEC (op 11) return a+1 and a−1, with mask 5'b01110. V is set for 0x7F→0x80 (INC) and 0x80→0x7F (DEC).
- R9: SER (op 12) returns 0xFF, has mask 0, and sets wr_en_o.
- R10: Code 15 is a no-operation: result 0, wr_en_o 0, mask 0. Every other non-compare code sets wr_en_o.
- R11: Every flag bit outside the mask is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (destination register) |
| b_i | input | 8 | Second operand (register or constant) |
| carry_i | input | 1 | Current C flag |
| zero_i | input | 1 | Current Z flag |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Destination write-back enable |
| flags_o | output | 5 | New flags {H,V,N,Z,C} |
| flag_mask_o | output | 5 | Flags this operation updates |

## Verification
The hardest case is a zero difference from SBC or CPC while zero_i is low, because Z must then stay 0. A plain subtract would set Z. The stimulus creates this case directly with equal operands, zero borrow and both values of zero_i. It also runs a two-byte compare chain where the low byte differs and the high byte matches. Half-carry borrow edges and the three signed overflow corners (0x7F+1, 0x80−1, negate 0x80) are driven by name. A seeded sweep over all codes follows.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_AND  = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_ANDN = 4'd7,
    OP_COM  = 4'd8,  OP_NEG = 4'd9,  OP_INC = 4'd10, OP_DEC = 4'd11,
    OP_SER  = 4'd12, OP_CP  = 4'd13, OP_CPC = 4'd14, OP_NOP = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    LG_AND, LG_OR, LG_XOR, LG_ANDN, LG_NOT
  } logic_op_e;

  localparam int NUM_FLG = 5;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_H = 4;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,   // carry in, or borrow in when sub_i
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_o,     // carry out, or borrow out when sub_i
  output logic              h_o,
  output logic              v_o
);
  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] y_eff;
  logic              ci_eff;
  logic [LO_W:0]     lo;
  logic [HI_W:0]     hi;

  // subtraction as x + ~y + ~borrow
  assign y_eff  = sub_i ? ~y_i : y_i;
  assign ci_eff = sub_i ? ~cin_i : cin_i;

  assign lo = {1'b0, x_i[LO_W-1:0]} + {1'b0, y_eff[LO_W-1:0]} + {{LO_W{1'b0}}, ci_eff};
  assign hi = {1'b0, x_i[DATA_W-1:LO_W]} + {1'b0, y_eff[DATA_W-1:LO_W]}
            + {{HI_W{1'b0}}, lo[LO_W]};

  assign sum_o = {hi[HI_W-1:0], lo[LO_W-1:0]};
  assign c_o   = hi[HI_W] ^ sub_i;
  assign h_o   = lo[LO_W] ^ sub_i;
  assign v_o   = (x_i[DATA_W-1] == y_eff[DATA_W-1]) && (sum_o[DATA_W-1] != x_i[DATA_W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic_op_e         sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      LG_ANDN: res_o = a_i & ~b_i;
      LG_NOT:  res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flag_ctl.sv
module alu8_flag_ctl
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e              op_i,
  input  logic [DATA_W-1:0]    res_i,
  input  logic                 c_add_i,
  input  logic                 h_add_i,
  input  logic                 v_add_i,
  input  logic                 zero_i,
  output logic [NUM_FLG-1:0]   flags_o,
  output logic [NUM_FLG-1:0]   mask_o,
  output logic                 wr_en_o
);
  logic [NUM_FLG-1:0] raw;
  logic               z_res;

  assign z_res = (res_i == '0);

  always_comb begin
    raw        = '0;
    mask_o     = '0;
    raw[FLG_Z] = z_res;
    raw[FLG_N] = res_i[DATA_W-1];
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_NEG, OP_CP: begin
        mask_o     = '1;
        raw[FLG_C] = c_add_i;
        raw[FLG_H] = h_add_i;
        raw[FLG_V] = v_add_i;
      end
      OP_SBC, OP_CPC: begin
        mask_o     = '1;
        raw[FLG_C] = c_add_i;
        raw[FLG_H] = h_add_i;
        raw[FLG_V] = v_add_i;
        raw[FLG_Z] = z_res & zero_i;  // chain: only clears
      end
      OP_AND, OP_OR, OP_XOR, OP_ANDN: begin
        mask_o[FLG_Z] = 1'b1;
        mask_o[FLG_N] = 1'b1;
        mask_o[FLG_V] = 1'b1;
      end
      OP_COM: begin
        mask_o[FLG_C] = 1'b1;
        mask_o[FLG_Z] = 1'b1;
        mask_o[FLG_N] = 1'b1;
        mask_o[FLG_V] = 1'b1;
        raw[FLG_C]    = 1'b1;
      end
      OP_INC, OP_DEC: begin
        mask_o[FLG_Z] = 1'b1;
        mask_o[FLG_N] = 1'b1;
        mask_o[FLG_V] = 1'b1;
        raw[FLG_V]    = v_add_i;
      end
      default: mask_o = '0;
    endcase
  end

  assign flags_o = raw & mask_o;
  assign wr_en_o = !(op_i inside {OP_CP, OP_CPC, OP_NOP});
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]          op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic                carry_i,
  input  logic                zero_i,
  output logic [DATA_W-1:0]   res_o,
  output logic                wr_en_o,
  output logic [NUM_FLG-1:0]  flags_o,
  output logic [NUM_FLG-1:0]  flag_mask_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  alu_op_e           op;
  logic [DATA_W-1:0] x, y, sum, lres;
  logic              cin, sub, c_add, h_add, v_add;
  logic_op_e         lsel;

  assign op = alu_op_e'(op_i);

  always_comb begin
    x    = a_i;
    y    = b_i;
    cin  = 1'b0;
    sub  = 1'b0;
    lsel = LG_AND;
    unique case (op)
      OP_ADC:        cin = carry_i;
      OP_SUB, OP_CP: sub = 1'b1;
      OP_SBC, OP_CPC: begin sub = 1'b1; cin = carry_i; end
      OP_NEG:        begin x = '0; y = a_i; sub = 1'b1; end
      OP_INC:        y = ONE;
      OP_DEC:        begin y = ONE; sub = 1'b1; end
      OP_OR:         lsel = LG_OR;
      OP_XOR:        lsel = LG_XOR;
      OP_ANDN:       lsel = LG_ANDN;
      OP_COM:        lsel = LG_NOT;
      default: ;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .x_i(x), .y_i(y), .cin_i(cin), .sub_i(sub),
    .sum_o(sum), .c_o(c_add), .h_o(h_add), .v_o(v_add)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .sel_i(lsel), .a_i(a_i), .b_i(b_i), .res_o(lres)
  );

  always_comb begin
    unique case (op)
      OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_COM: res_o = lres;
      OP_SER: res_o = '1;
      OP_NOP: res_o = '0;
      default: res_o = sum;
    endcase
  end

  alu8_flag_ctl #(.DATA_W(DATA_W)) u_flag_ctl (
    .op_i(op), .res_i(res_o), .c_add_i(c_add), .h_add_i(h_add), .v_add_i(v_add),
    .zero_i(zero_i), .flags_o(flags_o), .mask_o(flag_mask_o), .wr_en_o(wr_en_o)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              carry_i,
  input logic              zero_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_en_o,
  input logic [4:0]        flags_o,
  input logic [4:0]        flag_mask_o
);
  always_comb begin
    if (op_i == 4'd13 || op_i == 4'd14)
      assert_cmp_no_wb_R3: assert (!wr_en_o) else $error("compare wrote back");
    if ((op_i == 4'd3 || op_i == 4'd14) && !zero_i)
      assert_z_chain_R4: assert (!flags_o[1]) else $error("chained Z set");
    if (op_i >= 4'd4 && op_i <= 4'd7)
      assert_logic_v_clear_R5: assert (!flags_o[3] && flag_mask_o == 5'b01110)
        else $error("logic flags");
    if (op_i == 4'd8)
      assert_com_carry_R6: assert (flags_o[0] && res_o == ~a_i) else $error("com");
    if (op_i == 4'd10 || op_i == 4'd11)
      assert_incdec_keep_c_R8: assert (!flag_mask_o[0] && !flag_mask_o[4])
        else $error("inc/dec touched C/H");
    if (op_i == 4'd12)
      assert_ser_R9: assert (res_o == '1 && flag_mask_o == '0 && wr_en_o) else $error("ser");
    if (op_i == 4'd15)
      assert_nop_R10: assert (!wr_en_o && flag_mask_o == '0 && res_o == '0) else $error("nop");
    assert_outside_mask_R11: assert ((flags_o & ~flag_mask_o) == '0) else $error("flag leak");
    if (flag_mask_o[1] && op_i != 4'd3 && op_i != 4'd14)
      assert_z_result_R1: assert (flags_o[1] == (res_o == '0)) else $error("Z mismatch");
  end
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .zero_i(zero_i),
  .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o), .flag_mask_o(flag_mask_o)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op = 4'd15;
  logic [7:0] a = '0, b = '0;
  logic       ci = 1'b0, zi = 1'b0;
  logic [7:0] res;
  logic       wr;
  logic [4:0] flg, msk;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  alu8_core dut_i (
    .op_i(op), .a_i(a), .b_i(b), .carry_i(ci), .zero_i(zi),
    .res_o(res), .wr_en_o(wr), .flags_o(flg), .flag_mask_o(msk)
  );

  // returns {sum[7:0], c, h, v}
  function automatic logic [10:0] arith(input int x, input int y, input int cb, input bit sub);
    int r, rl, sx, sy, sr;
    sx = (x > 127) ? x - 256 : x;
    sy = (y > 127) ? y - 256 : y;
    if (sub) begin
      r = x - y - cb; rl = (x % 16) - (y % 16) - cb; sr = sx - sy - cb;
      return {8'(r), r < 0, rl < 0, (sr > 127 || sr < -128)};
    end
    r = x + y + cb; rl = (x % 16) + (y % 16) + cb; sr = sx + sy + cb;
    return {8'(r), r > 255, rl > 15, (sr > 127 || sr < -128)};
  endfunction

  // returns {res[7:0], wr, flags{H,V,N,Z,C}, mask}
  function automatic logic [18:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input bit c, input bit z);
    logic [10:0] ar;
    logic [7:0] r;
    logic cf = 0, hf = 0, vf = 0, zf, w;
    logic [4:0] m = 5'b00000, f;
    w = !(o == 13 || o == 14 || o == 15);
    ar = '0;
    case (o)
      0: ar = arith(x, y, 0, 0);
      1: ar = arith(x, y, c, 0);
      2, 13: ar = arith(x, y, 0, 1);
      3, 14: ar = arith(x, y, c, 1);
      9: ar = arith(0, x, 0, 1);
      10: ar = arith(x, 1, 0, 0);
      11: ar = arith(x, 1, 0, 1);
      default: ;
    endcase
    case (o)
      4: r = x & y;
      5: r = x | y;
      6: r = x ^ y;
      7: r = x & (8'hFF - y);
      8: r = 8'hFF - x;
      12: r = 8'hFF;
      15: r = 8'h00;
      default: r = ar[10:3];
    endcase
    zf = (r == 0);
    case (o)
      0, 1, 2, 9, 13: begin m = 5'b11111; cf = ar[2]; hf = ar[1]; vf = ar[0]; end
      3, 14: begin m = 5'b11111; cf = ar[2]; hf = ar[1]; vf = ar[0]; zf = zf && z; end
      4, 5, 6, 7: m = 5'b01110;
      8: begin m = 5'b01111; cf = 1; end
      10, 11: begin m = 5'b01110; vf = ar[0]; end
      default: m = 5'b00000;
    endcase
    f = {hf, vf, r[7], zf, cf} & m;
    return {r, w, f, m};
  endfunction

  task automatic run(input string tag, input logic [3:0] o, input logic [7:0] x,
                     input logic [7:0] y, input bit c, input bit z);
    logic [18:0] exp, act;
    @(posedge clk);
    op = o; a = x; b = y; ci = c; zi = z;
    @(negedge clk);
    exp = model(o, x, y, c, z);
    act = {res, wr, flg, msk};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0b z=%0b act res=%h wr=%0b f=%b m=%b exp res=%h wr=%0b f=%b m=%b",
               tag, o, x, y, c, z, act[18:11], act[10], act[9:5], act[4:0],
               exp[18:11], exp[10], exp[9:5], exp[4:0]);
    end
  endtask

  task automatic t_idle_state;  // R10: idle code while in reset
    logic [18:0] act;
    @(negedge clk);
    act = {res, wr, flg, msk};
    checks++;
    if (act !== 19'd0) begin
      fails++;
      $display("FAIL R10 idle act=%h exp=0", act);
    end
  endtask

  task automatic t_add;
    run("R1 add half", 0, 8'h0F, 8'h01, 1, 0);
    run("R1 add wrap", 0, 8'hFF, 8'h01, 0, 0);
    run("R1 add ovf", 0, 8'h7F, 8'h01, 0, 0);
    run("R1 adc carry", 1, 8'h80, 8'h7F, 1, 0);
    run("R1 adc nocarry", 1, 8'h12, 8'h34, 0, 1);
  endtask

  task automatic t_sub;
    run("R2 sub borrow", 2, 8'h00, 8'h01, 0, 0);
    run("R2 sub ovf", 2, 8'h80, 8'h01, 0, 0);
    run("R2 sub zero", 2, 8'h55, 8'h55, 1, 0);
    run("R2 sbc borrow", 3, 8'h10, 8'h0F, 1, 1);
  endtask

  task automatic t_compare;
    run("R3 cp equal", 13, 8'h3C, 8'h3C, 0, 0);
    run("R3 cp lower", 13, 8'h01, 8'h02, 0, 1);
    run("R3 cpc", 14, 8'hA0, 8'h20, 1, 0);
  endtask

  task automatic t_chain;
    run("R4 sbc zero keep", 3, 8'h44, 8'h44, 0, 1);
    run("R4 sbc zero clr", 3, 8'h44, 8'h44, 0, 0);
    run("R4 cpc lo differ", 13, 8'h05, 8'h06, 0, 0);   // low byte: borrow, Z=0
    run("R4 cpc hi match", 14, 8'h21, 8'h20, 1, 0);    // high byte equal after borrow, Z stays 0
    run("R4 cpc all match", 14, 8'h20, 8'h20, 0, 1);
  endtask

  task automatic t_logic;
    run("R5 and", 4, 8'hF0, 8'h0F, 1, 1);
    run("R5 or", 5, 8'h80, 8'h01, 0, 0);
    run("R5 xor", 6, 8'hAA, 8'hAA, 1, 0);
    run("R5 andn", 7, 8'hFF, 8'h0F, 0, 0);
  endtask

  task automatic t_com;
    run("R6 com ff", 8, 8'hFF, 8'h00, 0, 0);
    run("R6 com 0", 8, 8'h00, 8'h00, 0, 1);
  endtask

  task automatic t_neg;
    run("R7 neg 0", 9, 8'h00, 8'h00, 1, 0);
    run("R7 neg 80", 9, 8'h80, 8'h00, 0, 0);
    run("R7 neg 01", 9, 8'h01, 8'h00, 0, 0);
  endtask

  task automatic t_incdec;
    run("R8 inc 7f", 10, 8'h7F, 8'h00, 1, 0);
    run("R8 inc ff", 10, 8'hFF, 8'h00, 0, 0);
    run("R8 dec 80", 11, 8'h80, 8'h00, 0, 0);
    run("R8 dec 01", 11, 8'h01, 8'h00, 1, 0);
    run("R8 dec 00", 11, 8'h00, 8'h00, 0, 0);
  endtask

  task automatic t_ser_nop;
    run("R9 ser", 12, 8'h12, 8'h34, 1, 1);
    run("R10 nop", 15, 8'hFF, 8'hFF, 1, 1);
  endtask

  task automatic t_sweep;  // R11 masking over every code
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run("R11 sweep", 4'(i % 16), lfsr[7:0], lfsr[15:8], lfsr[3], lfsr[9]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_idle_state();
    rst_ni = 1'b1;
    t_add();
    t_sub();
    t_compare();
    t_chain();
    t_logic();
    t_com();
    t_neg();
    t_incdec();
    t_ser_nop();
    t_sweep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule